// File: doc/BRIEF.md
# Local Interrupt Pending Selector

This block chooses which local interrupt a hart takes next. It holds a 32-bit pending register. Interrupt sources change that register through atomic masked updates, and each update hands back the value the register held just before the write. The pending register is ANDed with the enable vector to form the candidates. Each candidate is then gated by one of two privilege-dependent global enables. A candidate whose delegation bit is set uses the supervisor-level enable. A candidate whose delegation bit is clear uses the machine-level enable. Of the candidates that survive, the lowest bit index wins. The block reports a valid flag and the winning cause number from registers, one cycle after its inputs change.

A separate claim register records which pending bits a source already owns. A claim request succeeds only when none of its bits is already owned. On success the requested bits are added to the claim register.

Privilege is encoded as user = 0, supervisor = 1, machine = 3. The external reset is asynchronous and active low. Its release is synchronised inside the block with two flops, so the block leaves reset on the second clock edge after the input rises.

Top module: `hart_irq_select`

## Requirements
- R1: While reset is active and right after it is released, `irq_valid` is 0, `irq_cause` is 0, `pend` is 0, `upd_done` is 0, `clm_done` is 0 and the claim register is empty.
- R2: A bit is a candidate only when it is set in both `pend` and `irq_en`. A pending bit whose enable is 0 is never reported.
- R3: Non-delegated candidates (`irq_deleg` bit 0) are eligible when `priv` is not 3. They are also eligible when `priv` is 3 and `m_gie` is 1.
- R4: Delegated candidates (`irq_deleg` bit 1) are eligible when `priv` is 0. They are also eligible when `priv` is 1 and `s_gie` is 1. They are never eligible when `priv` is 3.
- R5: When several bits are eligible, `irq_cause` is the lowest eligible bit index and `irq_valid` is 1.
- R6: When no bit is eligible, `irq_valid` is 0 and `irq_cause` is 0.
- R7: A cycle with `upd_req` = 1 replaces `pend` with (old AND NOT `upd_mask`) OR (`upd_value` AND `upd_mask`) on the next edge. Bits outside the mask keep their value. Without `upd_req`, `pend` holds its value.
- R8: On the edge after an update request, `upd_done` is 1 for one cycle and `upd_old` shows the `pend` value from before that update.
- R9: A claim request whose `clm_bits` overlap the claim register fails. On the next edge `clm_done` is 1 and `clm_ok` is 0, and the claim register is left unchanged.
- R10: A claim request with no overlap succeeds. On the next edge `clm_done` is 1 and `clm_ok` is 1, and the requested bits are ORed into the claim register.
- R11: `irq_valid` and `irq_cause` change exactly one clock edge after a change of `priv`, `m_gie`, `s_gie`, `irq_en`, `irq_deleg` or `pend`. Until that edge they keep their earlier value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset |
| priv | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| m_gie | input | 1 | Machine global interrupt enable |
| s_gie | input | 1 | Supervisor global interrupt enable |
| irq_en | input | 32 | Per-interrupt enable vector |
| irq_deleg | input | 32 | Per-interrupt delegation vector |
| upd_req | input | 1 | Pending update strobe |
| upd_mask | input | 32 | Bits that the update writes |
| upd_value | input | 32 | New values for the masked bits |
| upd_done | output | 1 | Update completed (one cycle) |
| upd_old | output | 32 | Pending value before the completed update |
| pend | output | 32 | Current pending register |
| clm_req | input | 1 | Claim request strobe |
| clm_bits | input | 32 | Bits to claim |
| clm_done | output | 1 | Claim answered (one cycle) |
| clm_ok | output | 1 | Claim succeeded |
| irq_valid | output | 1 | An interrupt is selected |
| irq_cause | output | 5 | Index of the selected interrupt |

## Verification
A corrupted pending bit shows up on `pend` on the next edge. It is visible one edge later as a wrong or missing `irq_cause`, and at the next update as a wrong `upd_old`. A wrong gate choice appears the edge after a privilege or enable change. It shows as a delegated bit that wins while it should be masked, or the reverse, so the tests walk the privilege levels against a mixed delegation vector. The claim register is visible only through claim answers. A stray claim bit therefore shows as a later non-overlapping claim that is refused, and a lost claim bit shows as a repeated claim that is granted, both on the edge after the request.

// File: rtl/irqsel_pkg.sv
`timescale 1ns/1ps
package irqsel_pkg;
  typedef enum logic [1:0] {
    PRIV_U   = 2'd0,
    PRIV_S   = 2'd1,
    PRIV_RSV = 2'd2,
    PRIV_M   = 2'd3
  } priv_e;
endpackage

// File: rtl/irqsel_rst_sync.sv
`timescale 1ns/1ps
module irqsel_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/irqsel_pend.sv
`timescale 1ns/1ps
module irqsel_pend #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         upd_req_i,
  input  logic [W-1:0] upd_mask_i,
  input  logic [W-1:0] upd_value_i,
  output logic [W-1:0] pend_o,
  output logic         upd_done_o,
  output logic [W-1:0] upd_old_o
);
  logic [W-1:0] pend_q, pend_d;
  logic [W-1:0] old_q;
  logic         done_q;

  always_comb begin
    pend_d = (pend_q & ~upd_mask_i) | (upd_value_i & upd_mask_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      old_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= upd_req_i;
      if (upd_req_i) begin
        pend_q <= pend_d;
        old_q  <= pend_q;
      end
    end
  end

  assign pend_o     = pend_q;
  assign upd_done_o = done_q;
  assign upd_old_o  = old_q;

  // R7
  masked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_req_i |=> ((pend_q & $past(upd_mask_i)) == ($past(upd_value_i) & $past(upd_mask_i))));
  // R7
  hold_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_req_i |=> $stable(pend_q));
  // R8
  old_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_req_i |=> (done_q && (old_q == $past(pend_q))));
endmodule

// File: rtl/irqsel_claim.sv
`timescale 1ns/1ps
module irqsel_claim #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clm_req_i,
  input  logic [W-1:0] clm_bits_i,
  output logic         clm_done_o,
  output logic         clm_ok_o
);
  logic [W-1:0] own_q, own_d;
  logic         done_q, ok_q;
  logic         clash;
  logic         grant;

  always_comb begin
    clash = |(own_q & clm_bits_i);
    grant = clm_req_i && !clash;
    own_d = own_q | clm_bits_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q  <= '0;
      done_q <= 1'b0;
      ok_q   <= 1'b0;
    end else begin
      done_q <= clm_req_i;
      ok_q   <= grant;
      if (grant) own_q <= own_d;
    end
  end

  assign clm_done_o = done_q;
  assign clm_ok_o   = ok_q;

  // R9
  clash_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clm_req_i && ((own_q & clm_bits_i) != '0)) |=> (done_q && !ok_q && $stable(own_q)));
  // R10
  grant_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clm_req_i && ((own_q & clm_bits_i) == '0)) |=> (ok_q && ((own_q & $past(clm_bits_i)) == $past(clm_bits_i))));
endmodule

// File: rtl/irqsel_pick.sv
`timescale 1ns/1ps
module irqsel_pick
  import irqsel_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           priv_i,
  input  logic                 m_gie_i,
  input  logic                 s_gie_i,
  input  logic [W-1:0]         pend_i,
  input  logic [W-1:0]         en_i,
  input  logic [W-1:0]         deleg_i,
  output logic                 valid_o,
  output logic [$clog2(W)-1:0] cause_o
);
  localparam int unsigned CW = $clog2(W);

  priv_e        lvl;
  logic         m_on, s_on;
  logic [W-1:0] cand, qual;
  logic         found;
  logic [CW-1:0] idx;
  logic         valid_q, valid_d;
  logic [CW-1:0] cause_q, cause_d;

  always_comb begin
    lvl  = priv_e'(priv_i);
    m_on = (lvl != PRIV_M) || m_gie_i;
    s_on = (lvl == PRIV_U) || ((lvl == PRIV_S) && s_gie_i);
    cand = pend_i & en_i;
  end

  for (genvar i = 0; i < W; i++) begin : g_gate
    assign qual[i] = cand[i] & (deleg_i[i] ? s_on : m_on);
  end

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = int'(W) - 1; i >= 0; i--) begin
      if (qual[i]) begin
        found = 1'b1;
        idx   = CW'(i);
      end
    end
    valid_d = found;
    cause_d = found ? idx : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      cause_q <= '0;
    end else begin
      valid_q <= valid_d;
      cause_q <= cause_d;
    end
  end

  assign valid_o = valid_q;
  assign cause_o = cause_q;

  // R2
  enabled_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> ((($past(pend_i & en_i) >> cause_q) & W'(1)) == W'(1)));
  // R5
  lowest_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> ((($past(qual) >> cause_q) & W'(1)) == W'(1)) &&
                (($past(qual) & ((W'(1) << cause_q) - W'(1))) == '0));
  // R6
  none_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(qual) == '0) |-> (!valid_q && (cause_q == '0)));
endmodule

// File: rtl/hart_irq_select.sv
`timescale 1ns/1ps
module hart_irq_select #(
  parameter int unsigned W = 32
) (
  input  logic                 clk,
  input  logic                 arst_n,
  input  logic [1:0]           priv,
  input  logic                 m_gie,
  input  logic                 s_gie,
  input  logic [W-1:0]         irq_en,
  input  logic [W-1:0]         irq_deleg,
  input  logic                 upd_req,
  input  logic [W-1:0]         upd_mask,
  input  logic [W-1:0]         upd_value,
  output logic                 upd_done,
  output logic [W-1:0]         upd_old,
  output logic [W-1:0]         pend,
  input  logic                 clm_req,
  input  logic [W-1:0]         clm_bits,
  output logic                 clm_done,
  output logic                 clm_ok,
  output logic                 irq_valid,
  output logic [$clog2(W)-1:0] irq_cause
);
  logic         rst_n;
  logic [W-1:0] pend_w;

  irqsel_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (arst_n),
    .rst_n_o (rst_n)
  );

  irqsel_pend #(.W(W)) u_pend (
    .clk         (clk),
    .rst_n       (rst_n),
    .upd_req_i   (upd_req),
    .upd_mask_i  (upd_mask),
    .upd_value_i (upd_value),
    .pend_o      (pend_w),
    .upd_done_o  (upd_done),
    .upd_old_o   (upd_old)
  );

  irqsel_claim #(.W(W)) u_claim (
    .clk        (clk),
    .rst_n      (rst_n),
    .clm_req_i  (clm_req),
    .clm_bits_i (clm_bits),
    .clm_done_o (clm_done),
    .clm_ok_o   (clm_ok)
  );

  irqsel_pick #(.W(W)) u_pick (
    .clk     (clk),
    .rst_n   (rst_n),
    .priv_i  (priv),
    .m_gie_i (m_gie),
    .s_gie_i (s_gie),
    .pend_i  (pend_w),
    .en_i    (irq_en),
    .deleg_i (irq_deleg),
    .valid_o (irq_valid),
    .cause_o (irq_cause)
  );

  assign pend = pend_w;
endmodule

// File: tb/hart_irq_select_test.sv
`timescale 1ns/1ps
module hart_irq_select_test;
  logic        clk = 1'b0;
  logic        arst_n;
  logic [1:0]  priv;
  logic        m_gie, s_gie;
  logic [31:0] irq_en, irq_deleg;
  logic        upd_req;
  logic [31:0] upd_mask, upd_value;
  logic        upd_done;
  logic [31:0] upd_old, pend;
  logic        clm_req;
  logic [31:0] clm_bits;
  logic        clm_done, clm_ok;
  logic        irq_valid;
  logic [4:0]  irq_cause;

  hart_irq_select uut (
    .clk(clk), .arst_n(arst_n), .priv(priv), .m_gie(m_gie), .s_gie(s_gie),
    .irq_en(irq_en), .irq_deleg(irq_deleg), .upd_req(upd_req),
    .upd_mask(upd_mask), .upd_value(upd_value), .upd_done(upd_done),
    .upd_old(upd_old), .pend(pend), .clm_req(clm_req), .clm_bits(clm_bits),
    .clm_done(clm_done), .clm_ok(clm_ok), .irq_valid(irq_valid),
    .irq_cause(irq_cause)
  );

  always #2 clk = ~clk;

  localparam int K_SEL = 0, K_PEND = 1, K_OLD = 2, K_CLM = 3;
  typedef struct {
    int          due;
    int          kind;
    logic [31:0] a;
    logic [31:0] b;
    string       tag;
  } exp_t;

  exp_t q[$];
  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [31:0] m_pend = '0;
  logic [31:0] m_claim = '0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [5:0] model_pick(logic [1:0] p, logic mg, logic sg,
                                            logic [31:0] pd, logic [31:0] en,
                                            logic [31:0] dl);
    logic mo, so;
    logic [31:0] e;
    mo = (p != 2'd3) || mg;
    so = (p == 2'd0) || (p == 2'd1 && sg);
    e  = pd & en & ((~dl & {32{mo}}) | (dl & {32{so}}));
    for (int i = 0; i < 32; i++) if (e[i]) return {1'b1, 5'(i)};
    return 6'd0;
  endfunction

  task automatic push(int due, int kind, logic [31:0] a, logic [31:0] b, string tag);
    exp_t e;
    e.due = due; e.kind = kind; e.a = a; e.b = b; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic push_sel(int due, string tag);
    logic [5:0] r;
    r = model_pick(priv, m_gie, s_gie, m_pend, irq_en, irq_deleg);
    push(due, K_SEL, {31'd0, r[5]}, {27'd0, r[4:0]}, tag);
  endtask

  task automatic idle2();
    @(posedge clk); #1;
    @(posedge clk); #1;
  endtask

  task automatic drive_sel(logic [1:0] p, logic mg, logic sg, logic [31:0] en,
                           logic [31:0] dl, string tag);
    push_sel(cyc, {"R11 hold ", tag});
    priv = p; m_gie = mg; s_gie = sg; irq_en = en; irq_deleg = dl;
    push_sel(cyc + 1, tag);
    idle2();
  endtask

  task automatic drive_upd(logic [31:0] mk, logic [31:0] vl, string tag);
    push(cyc + 1, K_OLD, 32'd1, m_pend, {"R8 ", tag});
    upd_req = 1'b1; upd_mask = mk; upd_value = vl;
    m_pend = (m_pend & ~mk) | (vl & mk);
    push(cyc + 1, K_PEND, m_pend, 32'd0, {"R7 ", tag});
    push_sel(cyc + 2, {"R5 ", tag});
    @(posedge clk); #1;
    upd_req = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic drive_clm(logic [31:0] bits, string tag);
    logic ok;
    ok = ((m_claim & bits) == 32'd0);
    if (ok) m_claim = m_claim | bits;
    push(cyc + 1, K_CLM, 32'd1, {31'd0, ok}, tag);
    clm_req = 1'b1; clm_bits = bits;
    @(posedge clk); #1;
    clm_req = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic report(string tag, logic [31:0] act_a, logic [31:0] act_b,
                        logic [31:0] exp_a, logic [31:0] exp_b);
    checks++;
    if (act_a !== exp_a || act_b !== exp_b) begin
      errors++;
      $display("FAIL %s: actual %h/%h expected %h/%h", tag, act_a, act_b, exp_a, exp_b);
    end
  endtask

  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      exp_t e;
      e = q.pop_front();
      if (e.due < cyc) begin
        checks++; errors++;
        $display("FAIL %s: expectation missed its cycle, actual none expected cycle %0d", e.tag, e.due);
      end else begin
        case (e.kind)
          K_SEL:  report(e.tag, {31'd0, irq_valid}, {27'd0, irq_cause}, e.a, e.b);
          K_PEND: report(e.tag, pend, 32'd0, e.a, 32'd0);
          K_OLD:  report(e.tag, {31'd0, upd_done}, upd_old, e.a, e.b);
          default: report(e.tag, {31'd0, clm_done}, {31'd0, clm_ok}, e.a, e.b);
        endcase
      end
    end
  end

  initial begin
    #(100000 * 4);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    arst_n = 1'b0; priv = 2'd3; m_gie = 1'b0; s_gie = 1'b0;
    irq_en = '0; irq_deleg = '0; upd_req = 1'b0; upd_mask = '0;
    upd_value = '0; clm_req = 1'b0; clm_bits = '0;
    repeat (5) @(posedge clk);
    #1 arst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    push(cyc, K_SEL, 32'd0, 32'd0, "R1 select idle");
    push(cyc, K_PEND, 32'd0, 32'd0, "R1 pending clear");
    push(cyc, K_OLD, 32'd0, 32'd0, "R1 no update done");
    push(cyc, K_CLM, 32'd0, 32'd0, "R1 no claim done");
    idle2();

    drive_sel(2'd3, 1'b1, 1'b0, 32'hFFFF_FFFF, 32'h0, "R3 machine enabled, nothing pending R6");
    drive_upd(32'hFFFF_FFFF, 32'h0000_00A0, "full write, lowest of bits 5 and 7");
    drive_upd(32'h0000_00F0, 32'h0000_0010, "partial mask");
    drive_upd(32'h8000_0000, 32'hFFFF_FFFF, "top bit only, others kept");
    drive_sel(2'd3, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'h0, "R3 machine gie off in M");
    drive_sel(2'd1, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'h0, "R3 below machine ignores m_gie");
    drive_sel(2'd1, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'h0000_0010, "R4 delegated masked in S, R5 bit 31");
    drive_sel(2'd1, 1'b0, 1'b1, 32'hFFFF_FFFF, 32'h0000_0010, "R4 s_gie on in S");
    drive_sel(2'd3, 1'b1, 1'b1, 32'hFFFF_FFFF, 32'h0000_0010, "R4 delegated never in M");
    drive_sel(2'd0, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'h0000_0010, "R4 user enables both");
    drive_sel(2'd0, 1'b0, 1'b0, 32'hFFFF_FFEF, 32'h0000_0010, "R2 disabled bit skipped");
    drive_sel(2'd0, 1'b0, 1'b0, 32'h0000_0000, 32'h0000_0010, "R6 all disabled");
    drive_sel(2'd0, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'h0000_0000, "R5 re-enable");
    drive_upd(32'h0000_0010, 32'h0000_0000, "clear bit 4");
    drive_upd(32'hFFFF_FFFF, 32'h0000_0000, "clear all R6");

    drive_clm(32'h0000_0003, "R10 first claim granted");
    drive_clm(32'h0000_0006, "R9 overlap refused");
    drive_clm(32'h0000_0004, "R9 refused bits not kept, R10 granted");
    drive_clm(32'h0000_0004, "R10 granted bits kept, R9 refused");
    drive_clm(32'h8000_0000, "R10 disjoint high bit");

    repeat (4) @(posedge clk);
    #1;
    if (q.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard: actual %0d pending expected 0", q.size());
    end
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule